// File: doc/BRIEF.md
# Stop-Clock Request Sequencer

This block turns an asynchronous, active-low request to halt the core clock into an ordered handshake. A request first passes through a synchronizer. The machine then waits for an instruction boundary at which no higher-priority interrupt is pending. Next it asks the core to empty its pipelines and write buffers. After that it requests a stop-grant acknowledge bus cycle, and that cycle ends when the system returns either of two ready signals. Only then does it tell the clock controller that the clock may be stopped. Gating the clock itself is left to the controller.

The request must stay asserted through the whole sequence. If the requester withdraws it before the acknowledge cycle has been terminated, the machine raises a one-cycle protocol error and goes back to running. After a completed stop, the stopped flag stays up until the request is released, and the machine then returns to running without an error.

The states are RUN, WAIT_BND, DRAIN, ACK and STOPPED, one-hot encoded. They are linked by these transitions:
- req_seen: RUN to WAIT_BND
- bnd_ok: WAIT_BND to DRAIN, on a boundary with no interrupt pending
- drained: DRAIN to ACK, on drain_done
- acked: ACK to STOPPED, on bus_ready or burst_ready
- released: STOPPED to RUN
- abort: WAIT_BND, DRAIN or ACK to RUN, when the request drops

Top module: `stop_clk_seq`

## Requirements
- R1: `stop_req_n` is active low and passes through SYNC_STAGES flip-flops, which reset to the inactive level. When a boundary is already present with no interrupt pending, `drain_req` rises SYNC_STAGES+2 rising edges after the request goes low, and not earlier.
- R2: After reset, and while no request is present, all four outputs are low. `insn_boundary`, `drain_done`, `bus_ready` and `burst_ready` then have no effect.
- R3: A boundary that arrives while `hi_irq_pending` is high does not start draining. The sequence waits for a later boundary that has no pending interrupt.
- R4: `drain_req` stays high until `drain_done` is sampled high. `stop_grant_req` rises on the following edge and never rises before draining has completed.
- R5: `bus_ready` and `burst_ready` are ignored in every state other than ACK. In particular, a ready during DRAIN neither starts nor ends a stop-grant cycle.
- R6: The acknowledge cycle (`stop_grant_req` high) is terminated by `bus_ready` or by `burst_ready`, both active high. `clk_stop_ok` rises on the next edge.
- R7: `clk_stop_ok` stays high while the synchronized request stays asserted. When the request is released, all outputs return low and no error is flagged.
- R8: If the synchronized request drops in WAIT_BND, DRAIN or ACK, `proto_err` is high for exactly one cycle and the machine returns to RUN without raising `clk_stop_ok`. A drop in the same cycle as a ready counts as an abort.
- R9: The state is one-hot, and at most one of `drain_req`, `stop_grant_req` and `clk_stop_ok` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| insn_boundary | input | 1 | High in a cycle that is an instruction boundary |
| hi_irq_pending | input | 1 | A higher-priority interrupt is pending |
| drain_done | input | 1 | Pipelines and write buffers are empty |
| bus_ready | input | 1 | Normal ready for the acknowledge cycle, active high |
| burst_ready | input | 1 | Burst ready for the acknowledge cycle, active high |
| drain_req | output | 1 | Asks the core to drain its pipelines and write buffers |
| stop_grant_req | output | 1 | Asks the bus unit to run the stop-grant acknowledge cycle |
| clk_stop_ok | output | 1 | The clock may now be stopped |
| proto_err | output | 1 | One-cycle pulse: the request was withdrawn too early |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This makes the synchronizer depth visible in the measured request-to-drain latency, which has to be exactly five edges. It also shows that the latency tracks the parameter and is not a fixed constant. With that depth, every abort point (WAIT_BND, DRAIN, ACK) can be reached by simply holding the request released for a few cycles. Both termination paths and the ignored-ready case during DRAIN are then compared event by event against the expected order.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [4:0] {
        ST_RUN      = 5'b00001,
        ST_WAIT_BND = 5'b00010,
        ST_DRAIN    = 5'b00100,
        ST_ACK      = 5'b01000,
        ST_STOPPED  = 5'b10000
    } sc_state_e;

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic req_active
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign req_active = ~chain[LAST];

    initial begin
        p_min_stages_r1: assert (STAGES >= 2)
            else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic insn_boundary,
    input  logic hi_irq_pending,
    input  logic drain_done,
    input  logic bus_ready,
    input  logic burst_ready,
    output logic drain_req,
    output logic stop_grant_req,
    output logic clk_stop_ok,
    output logic proto_err
);
    sc_state_e state_q, state_d;
    logic      abort_d;
    logic      err_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        abort_d = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (req_sync) state_d = ST_WAIT_BND;              // req_seen
            end
            ST_WAIT_BND: begin
                if (!req_sync) begin
                    state_d = ST_RUN;                             // abort
                    abort_d = 1'b1;
                end else if (insn_boundary && !hi_irq_pending) begin
                    state_d = ST_DRAIN;                           // bnd_ok
                end
            end
            ST_DRAIN: begin
                if (!req_sync) begin
                    state_d = ST_RUN;
                    abort_d = 1'b1;
                end else if (drain_done) begin
                    state_d = ST_ACK;                             // drained
                end
            end
            ST_ACK: begin
                if (!req_sync) begin
                    state_d = ST_RUN;
                    abort_d = 1'b1;
                end else if (bus_ready || burst_ready) begin
                    state_d = ST_STOPPED;                         // acked
                end
            end
            ST_STOPPED: begin
                if (!req_sync) state_d = ST_RUN;                  // released
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= abort_d;
        end
    end

    // outputs
    always_comb begin
        drain_req      = 1'b0;
        stop_grant_req = 1'b0;
        clk_stop_ok    = 1'b0;
        unique case (state_q)
            ST_DRAIN:   drain_req      = 1'b1;
            ST_ACK:     stop_grant_req = 1'b1;
            ST_STOPPED: clk_stop_ok    = 1'b1;
            default: ;
        endcase
        proto_err = err_q;
    end

    p_onehot_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q));

    p_excl_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req, stop_grant_req, clk_stop_ok}));

    p_drain_at_clean_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_req) |-> $past(insn_boundary && !hi_irq_pending && req_sync));

    p_grant_after_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_grant_req) |-> $past(drain_req && drain_done));

    p_stop_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop_ok) |-> $past(stop_grant_req && (bus_ready || burst_ready)));

    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_ok && req_sync) |=> clk_stop_ok);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(!req_sync && !clk_stop_ok));

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);
endmodule

// File: rtl/stop_clk_seq.sv
module stop_clk_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_n,
    input  logic insn_boundary,
    input  logic hi_irq_pending,
    input  logic drain_done,
    input  logic bus_ready,
    input  logic burst_ready,
    output logic drain_req,
    output logic stop_grant_req,
    output logic clk_stop_ok,
    output logic proto_err
);
    logic req_sync;

    stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_n    (stop_req_n),
        .req_active (req_sync)
    );

    stopclk_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_sync       (req_sync),
        .insn_boundary  (insn_boundary),
        .hi_irq_pending (hi_irq_pending),
        .drain_done     (drain_done),
        .bus_ready      (bus_ready),
        .burst_ready    (burst_ready),
        .drain_req      (drain_req),
        .stop_grant_req (stop_grant_req),
        .clk_stop_ok    (clk_stop_ok),
        .proto_err      (proto_err)
    );
endmodule

// File: tb/sim_stop_clk_seq.sv
module sim_stop_clk_seq;
    localparam int N = 3;
    // event codes: 1 drain rise, 2 grant rise, 3 stop rise, 4 error pulse, 5 stop fall
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req_n = 1'b1, insn_boundary = 1'b0, hi_irq_pending = 1'b0;
    logic drain_done = 1'b0, bus_ready = 1'b0, burst_ready = 1'b0;
    logic drain_req, stop_grant_req, clk_stop_ok, proto_err;
    int   vectors = 0, fails = 0;
    int   exp_q[$];
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    stop_clk_seq #(.SYNC_STAGES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
        .insn_boundary(insn_boundary), .hi_irq_pending(hi_irq_pending),
        .drain_done(drain_done), .bus_ready(bus_ready), .burst_ready(burst_ready),
        .drain_req(drain_req), .stop_grant_req(stop_grant_req),
        .clk_stop_ok(clk_stop_ok), .proto_err(proto_err)
    );

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ev(int code);
        exp_q.push_back(code);
    endtask

    task automatic observe(int code);
        int e;
        if (exp_q.size() == 0) e = -1;
        else e = exp_q.pop_front();
        chk("event order R2-scoreboard", code, e);
    endtask

    // monitor: samples 2 ns after each rising edge
    initial begin
        logic pd = 0, pg = 0, ps = 0;
        forever begin
            @(posedge clk); #2;
            if (mon_on) begin
                if (drain_req && !pd)      observe(1);
                if (stop_grant_req && !pg) observe(2);
                if (clk_stop_ok && !ps)    observe(3);
                if (proto_err)             observe(4);
                if (!clk_stop_ok && ps)    observe(5);
            end
            pd = drain_req; pg = stop_grant_req; ps = clk_stop_ok;
        end
    end

    task automatic go_to_drain();
        stop_req_n = 1'b0; insn_boundary = 1'b1;
        tick(N + 2);
        insn_boundary = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        tick(3);
        // R2: reset state
        chk("R2 reset outputs", {drain_req, stop_grant_req, clk_stop_ok, proto_err}, 0);
        rst_n = 1'b1; mon_on = 1'b1;
        tick(2);

        // R2: no request -> stimulus ignored
        insn_boundary = 1; drain_done = 1; bus_ready = 1; burst_ready = 1;
        tick(4);
        chk("R2 idle ignores inputs", {drain_req, stop_grant_req, clk_stop_ok, proto_err}, 0);
        insn_boundary = 0; drain_done = 0; bus_ready = 0; burst_ready = 0;
        tick(2);

        // R1/R4/R5/R6/R7: full stop via bus_ready
        expect_ev(1); expect_ev(2); expect_ev(3); expect_ev(5);
        stop_req_n = 1'b0; insn_boundary = 1'b1;
        tick(N + 1);
        chk("R1 no drain before N+2 edges", drain_req, 0);
        tick(1);
        chk("R1 drain at N+2 edges", drain_req, 1);
        insn_boundary = 0;
        tick(3);
        chk("R4 drain held without done", drain_req, 1);
        bus_ready = 1'b1;
        tick(2);
        chk("R5 ready ignored in drain (grant)", stop_grant_req, 0);
        chk("R5 ready ignored in drain (stop)", clk_stop_ok, 0);
        bus_ready = 1'b0; drain_done = 1'b1;
        tick(1);
        drain_done = 1'b0;
        chk("R4 grant after drain_done", stop_grant_req, 1);
        tick(3);
        chk("R6 grant held awaiting ready", stop_grant_req, 1);
        bus_ready = 1'b1;
        tick(1);
        bus_ready = 1'b0;
        chk("R6 stopped after bus_ready", clk_stop_ok, 1);
        tick(6);
        chk("R7 stopped held", clk_stop_ok, 1);
        stop_req_n = 1'b1;
        tick(N + 2);
        chk("R7 release returns low", {drain_req, stop_grant_req, clk_stop_ok, proto_err}, 0);

        // R3/R6: interrupt defers, burst_ready terminates
        expect_ev(1); expect_ev(2); expect_ev(3); expect_ev(5);
        stop_req_n = 1'b0;
        tick(N + 4);
        chk("R3 waits for boundary", drain_req, 0);
        insn_boundary = 1; hi_irq_pending = 1;
        tick(3);
        chk("R3 interrupt defers drain", drain_req, 0);
        hi_irq_pending = 0;
        tick(1);
        insn_boundary = 0;
        chk("R3 later clean boundary drains", drain_req, 1);
        drain_done = 1; tick(1); drain_done = 0;
        burst_ready = 1; tick(1); burst_ready = 0;
        chk("R6 stopped after burst_ready", clk_stop_ok, 1);
        stop_req_n = 1'b1;
        tick(N + 3);

        // R8: abort in WAIT_BND
        expect_ev(4);
        stop_req_n = 1'b0; tick(N + 3);
        stop_req_n = 1'b1; tick(N + 3);
        chk("R8 abort in wait, no stop", clk_stop_ok, 0);

        // R8: abort in DRAIN
        expect_ev(1); expect_ev(4);
        go_to_drain();
        tick(2);
        stop_req_n = 1'b1; tick(N + 3);
        chk("R8 abort in drain, drain cleared", drain_req, 0);

        // R8: abort in ACK
        expect_ev(1); expect_ev(2); expect_ev(4);
        go_to_drain();
        drain_done = 1; tick(1); drain_done = 0;
        tick(2);
        stop_req_n = 1'b1; tick(N + 3);
        chk("R8 abort in ack, no stop", {stop_grant_req, clk_stop_ok}, 0);

        tick(4);
        chk("R9 all expected events seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule